// File: doc/BRIEF.md
# Four-Stage Pipelined Integer Multiplier

This unit is a side pipeline next to the execute stage of a 32-bit in-order core. It can take one multiply on every clock cycle. Each multiply carries two 32-bit operands, a 2-bit form code and a 5-bit destination register. The unit never forms a full 32x32 product in one cycle. Each operand is widened to 33 bits and split into a 16-bit low half and a 17-bit signed high half. The partial products are then spread over four register stages. The chosen 32-bit word comes out on a dedicated second register-file write port.

The core's hazard logic reads a per-stage busy vector and the destination register held in each stage. It can suppress a queued write by driving the register number that a younger instruction will write (the write-cancel input). It can also empty the whole pipe with a flush. Once an instruction is cancelled it stays cancelled until it leaves the unit.

Top module: `mul_pipe4`

## Requirements
- R1: `in_op` selects the word that is returned. 2'b00 gives the low 32 bits of the product. 2'b01 gives the high 32 bits with both operands signed. 2'b10 gives the high 32 bits with `in_a` signed and `in_b` unsigned. 2'b11 gives the high 32 bits with both operands unsigned.
- R2: A multiply is captured when `in_valid` is high at a rising edge. Call that edge k. Its result is on `wb_data` and `wb_rd` in the cycle that follows edge k+3.
- R3: A new multiply can be accepted at every edge, and back-to-back multiplies come out in order, one per cycle.
- R4: `stage_busy[i]` is high when stage i+1 holds an instruction. When it is high, `stage_rd[5*i+4:5*i]` holds that instruction's destination.
- R5: At a rising edge, `cancel_rd` is compared with the destination of the instruction being issued and of the instructions in stages 1 to 3. A nonzero `cancel_rd` that matches an instruction's destination marks it cancelled, and `wb_en` stays low when it reaches stage 4. Cancellation is sticky. An instruction already in stage 4 is not affected.
- R6: A `cancel_rd` of zero, or one that matches no destination, changes no result.
- R7: `wb_en` is high only when stage 4 holds a valid instruction that is not cancelled and whose destination is nonzero.
- R8: `flush` high at an edge empties all four stages, and the multiply presented at that edge is dropped.
- R9: `rst` high at an edge (synchronous, active high) empties all stages and clears all data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties every stage at the next edge |
| in_valid | input | 1 | A multiply is offered |
| in_op | input | 2 | Form code (see R1) |
| in_rd | input | 5 | Destination register |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| cancel_rd | input | 5 | Register whose pending multiply writes are cancelled; zero means none |
| wb_en | output | 1 | Second write port enable |
| wb_rd | output | 5 | Second write port register |
| wb_data | output | 32 | Second write port data |
| stage_busy | output | 4 | Valid bit of stages 1 to 4 |
| stage_rd | output | 20 | Destination held in each stage, 5 bits per stage, stage 1 lowest |

## Verification
The busy bit and destination of stage 1 are due in the cycle after the capturing edge. Each later edge moves them one stage. The write-port outputs are due after the fourth edge. The bench drives inputs and samples outputs at the falling edge. At each falling edge it compares the outputs with a four-entry model of the pipe, which advances once per rising edge. When the model advances, it applies the cancel value present at that edge to the entries being moved and to the new issue, so a suppressed write is expected in exactly the cycle the instruction would have retired. One directed case counts the cycles between issue and `wb_en` and checks that the count is four.

// File: rtl/mulp_pkg.sv
`timescale 1ns/1ps
package mulp_pkg;
    localparam int XLEN = 32;
    localparam int HALF = XLEN / 2;
    localparam int HIW  = HALF + 1;
    localparam int PPW  = 2 * HIW;
    localparam int PW   = 2 * XLEN;
    localparam int RW   = 5;
    localparam int NSTG = 4;

    typedef enum logic [1:0] {
        OP_LO    = 2'b00,
        OP_HI_SS = 2'b01,
        OP_HI_SU = 2'b10,
        OP_HI_UU = 2'b11
    } mop_e;

    typedef struct packed {
        logic            valid;
        mop_e            op;
        logic [RW-1:0]   rd;
        logic            killed;
    } mtag_t;

    function automatic logic a_is_signed(mop_e op);
        return (op == OP_HI_SS) || (op == OP_HI_SU);
    endfunction

    function automatic logic b_is_signed(mop_e op);
        return op == OP_HI_SS;
    endfunction

    function automatic logic cancel_hit(mtag_t t, logic [RW-1:0] c);
        return t.valid && (c != '0) && (c == t.rd);
    endfunction
endpackage

// File: rtl/mulp_split.sv
`timescale 1ns/1ps
module mulp_split import mulp_pkg::*; (
    input  mop_e                   op,
    input  logic [XLEN-1:0]        a,
    input  logic [XLEN-1:0]        b,
    output logic signed [HIW-1:0]  a_hi,
    output logic [HALF-1:0]        a_lo,
    output logic signed [HIW-1:0]  b_hi,
    output logic [HALF-1:0]        b_lo
);
    logic [XLEN:0] ea, eb;

    always_comb begin
        ea   = {a_is_signed(op) & a[XLEN-1], a};
        eb   = {b_is_signed(op) & b[XLEN-1], b};
        a_lo = ea[HALF-1:0];
        b_lo = eb[HALF-1:0];
        a_hi = ea[XLEN:HALF];
        b_hi = eb[XLEN:HALF];
    end
endmodule

// File: rtl/mulp_tags.sv
`timescale 1ns/1ps
module mulp_tags import mulp_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  mtag_t                   in_tag,
    input  logic [RW-1:0]           cancel_rd,
    output mtag_t [NSTG-1:0]        tags
);
    for (genvar i = 0; i < NSTG; i++) begin : g_stg
        mtag_t prev;
        mtag_t q;
        if (i == 0) begin : g_first
            assign prev = in_tag;
        end else begin : g_rest
            assign prev = tags[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                q <= '0;
            end else begin
                q        <= prev;
                q.killed <= prev.killed | cancel_hit(prev, cancel_rd);
            end
        end

        assign tags[i] = q;
    end
endmodule

// File: rtl/mulp_core.sv
`timescale 1ns/1ps
module mulp_core import mulp_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic signed [HIW-1:0]   a_hi,
    input  logic [HALF-1:0]         a_lo,
    input  logic signed [HIW-1:0]   b_hi,
    input  logic [HALF-1:0]         b_lo,
    input  mop_e                    sel_op,
    output logic [XLEN-1:0]         word
);
    logic signed [HIW-1:0] r1_ahi, r1_bhi, r2_ahi, r2_bhi;
    logic [HALF-1:0]       r1_alo, r1_blo;
    logic [XLEN-1:0]       r1_ll, r2_ll, r3_ll;
    logic signed [PPW-1:0] r2_lh, r2_hl, r3_hh, r3_mid;
    logic [XLEN-1:0]       r4_word;
    logic [PW-1:0]         product;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            r1_ahi <= '0; r1_bhi <= '0; r1_alo <= '0; r1_blo <= '0; r1_ll <= '0;
            r2_ahi <= '0; r2_bhi <= '0; r2_ll <= '0; r2_lh <= '0; r2_hl <= '0;
            r3_ll  <= '0; r3_hh  <= '0; r3_mid <= '0;
            r4_word <= '0;
        end else begin
            r1_ahi <= a_hi;
            r1_bhi <= b_hi;
            r1_alo <= a_lo;
            r1_blo <= b_lo;
            r1_ll  <= a_lo * b_lo;
            r2_ahi <= r1_ahi;
            r2_bhi <= r1_bhi;
            r2_ll  <= r1_ll;
            r2_lh  <= $signed({1'b0, r1_alo}) * r1_bhi;
            r2_hl  <= r1_ahi * $signed({1'b0, r1_blo});
            r3_ll  <= r2_ll;
            r3_hh  <= r2_ahi * r2_bhi;
            r3_mid <= r2_lh + r2_hl;
            r4_word <= (sel_op == OP_LO) ? product[XLEN-1:0] : product[PW-1:XLEN];
        end
    end

    always_comb begin
        product = {{(PW-XLEN){1'b0}}, r3_ll}
                + ({{(PW-PPW){r3_mid[PPW-1]}}, r3_mid} << HALF)
                + ({{(PW-PPW){r3_hh[PPW-1]}},  r3_hh}  << XLEN);
    end

    assign word = r4_word;
endmodule

// File: rtl/mul_pipe4.sv
`timescale 1ns/1ps
module mul_pipe4 import mulp_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 in_valid,
    input  logic [1:0]           in_op,
    input  logic [4:0]           in_rd,
    input  logic [31:0]          in_a,
    input  logic [31:0]          in_b,
    input  logic [4:0]           cancel_rd,
    output logic                 wb_en,
    output logic [4:0]           wb_rd,
    output logic [31:0]          wb_data,
    output logic [3:0]           stage_busy,
    output logic [19:0]          stage_rd
);
    mtag_t                 in_tag;
    mtag_t [NSTG-1:0]      tags;
    logic signed [HIW-1:0] a_hi, b_hi;
    logic [HALF-1:0]       a_lo, b_lo;

    assign in_tag = '{valid: in_valid, op: mop_e'(in_op), rd: in_rd, killed: 1'b0};

    mulp_split u_split (
        .op(mop_e'(in_op)), .a(in_a), .b(in_b),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
    );

    mulp_tags u_tags (
        .clk(clk), .rst(rst), .flush(flush),
        .in_tag(in_tag), .cancel_rd(cancel_rd), .tags(tags)
    );

    mulp_core u_core (
        .clk(clk), .rst(rst), .flush(flush),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
        .sel_op(tags[NSTG-2].op), .word(wb_data)
    );

    for (genvar i = 0; i < NSTG; i++) begin : g_out
        assign stage_busy[i]          = tags[i].valid;
        assign stage_rd[i*RW +: RW]   = tags[i].rd;
    end

    assign wb_rd = tags[NSTG-1].rd;
    assign wb_en = tags[NSTG-1].valid && !tags[NSTG-1].killed && (tags[NSTG-1].rd != '0);
endmodule

// File: rtl/mul_pipe4_chk.sv
`timescale 1ns/1ps
module mul_pipe4_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        in_valid,
    input logic [1:0]  in_op,
    input logic [4:0]  in_rd,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic [4:0]  cancel_rd,
    input logic        wb_en,
    input logic [4:0]  wb_rd,
    input logic [31:0] wb_data,
    input logic [3:0]  stage_busy,
    input logic [19:0] stage_rd
);
    // R9
    a_r9_reset_empties: assert property (@(posedge clk) rst |=> stage_busy == 4'b0);
    // R8
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> stage_busy == 4'b0);
    // R2, R4
    a_r2_issue_lands_s1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush) |=> (stage_busy[0] && stage_rd[4:0] == $past(in_rd)));
    // R3
    a_r3_s1_advances: assert property (@(posedge clk) disable iff (rst)
        (stage_busy[0] && !flush) |=> (stage_busy[1] && stage_rd[9:5] == $past(stage_rd[4:0])));
    // R5
    a_r5_cancel_s3_blocks: assert property (@(posedge clk) disable iff (rst)
        (stage_busy[2] && cancel_rd != 5'd0 && cancel_rd == stage_rd[14:10] && !flush) |=> !wb_en);
    // R7
    a_r7_wb_from_s4: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (stage_busy[3] && wb_rd != 5'd0));
endmodule

bind mul_pipe4 mul_pipe4_chk u_chk (.*);

// File: tb/tb_mul_pipe4.sv
`timescale 1ns/1ps
module tb_mul_pipe4;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [4:0]  in_rd = 5'd0;
    logic [31:0] in_a = 32'd0;
    logic [31:0] in_b = 32'd0;
    logic [4:0]  cancel_rd = 5'd0;
    logic        wb_en;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;
    logic [3:0]  stage_busy;
    logic [19:0] stage_rd;

    mul_pipe4 dut (.*);

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur = "R9";
    int    cyc = 0;

    logic        m_v [4];
    logic        m_k [4];
    logic [4:0]  m_rd [4];
    logic [31:0] m_w [4];

    function automatic logic [31:0] ref_word(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        logic [63:0] xa, xb, p;
        xa = (op == 2'b01 || op == 2'b10) ? {{32{a[31]}}, a} : {32'd0, a};
        xb = (op == 2'b01) ? {{32{b[31]}}, b} : {32'd0, b};
        p  = xa * xb;
        return (op == 2'b00) ? p[31:0] : p[63:32];
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic check_outputs();
        logic exp_en;
        for (int i = 0; i < 4; i++) begin
            chk("R4", "stage_busy bit", {31'd0, stage_busy[i]}, {31'd0, m_v[i]});
            if (m_v[i]) chk("R4", "stage_rd", {27'd0, stage_rd[i*5 +: 5]}, {27'd0, m_rd[i]});
        end
        exp_en = m_v[3] && !m_k[3] && m_rd[3] != 5'd0;
        chk((m_v[3] && m_k[3]) ? "R5" : cur, "wb_en", {31'd0, wb_en}, {31'd0, exp_en});
        if (exp_en) begin
            chk("R2", "wb_rd", {27'd0, wb_rd}, {27'd0, m_rd[3]});
            chk("R1", "wb_data", wb_data, m_w[3]);
        end
    endtask

    task automatic model_edge();
        if (rst || flush) begin
            for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_k[i] = 0; m_rd[i] = '0; m_w[i] = '0; end
        end else begin
            for (int i = 3; i > 0; i--) begin
                m_v[i]  = m_v[i-1];
                m_k[i]  = m_k[i-1] | (m_v[i-1] && cancel_rd != 0 && cancel_rd == m_rd[i-1]);
                m_rd[i] = m_rd[i-1];
                m_w[i]  = m_w[i-1];
            end
            m_v[0]  = in_valid;
            m_k[0]  = in_valid && cancel_rd != 0 && cancel_rd == in_rd;
            m_rd[0] = in_rd;
            m_w[0]  = ref_word(in_op, in_a, in_b);
        end
    endtask

    task automatic step(logic v, logic [1:0] op, logic [4:0] rd, logic [31:0] a, logic [31:0] b,
                        logic [4:0] cr, logic fl);
        check_outputs();
        in_valid = v; in_op = op; in_rd = rd; in_a = a; in_b = b; cancel_rd = cr; flush = fl;
        model_edge();
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 2'b00, 5'd0, 32'd0, 32'd0, 5'd0, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_k[i] = 0; m_rd[i] = '0; m_w[i] = '0; end
        @(negedge clk);
        model_edge();
        @(posedge clk); @(negedge clk);
        model_edge();
        @(posedge clk); @(negedge clk);
        // R9: reset state
        cur = "R9";
        chk("R9", "busy after reset", {28'd0, stage_busy}, 32'd0);
        chk("R9", "wb_en after reset", {31'd0, wb_en}, 32'd0);
        chk("R9", "wb_data after reset", wb_data, 32'd0);
        rst = 1'b0;

        // R1: each form with signed corner operands
        cur = "R1";
        step(1, 2'b00, 5'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        step(1, 2'b01, 5'd2, 32'h8000_0000, 32'h8000_0000, 0, 0);
        step(1, 2'b10, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        step(1, 2'b11, 5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        step(1, 2'b01, 5'd5, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0);
        step(1, 2'b10, 5'd6, 32'h8000_0001, 32'h0001_8000, 0, 0);
        idle(5);

        // R2: latency measured directly
        cur = "R2";
        step(1, 2'b11, 5'd9, 32'd12345, 32'd678, 0, 0);
        lat = 1;
        while (!wb_en && lat < 10) begin idle(1); lat++; end
        chk("R2", "latency cycles", lat, 32'd4);
        chk("R2", "latency data", wb_data, ref_word(2'b11, 32'd12345, 32'd678));
        idle(4);

        // R3: back-to-back stream
        cur = "R3";
        for (int i = 0; i < 12; i++)
            step(1, 2'(i), 5'(i + 10), $urandom, $urandom, 0, 0);
        idle(5);

        // R5: cancel while at issue, stage 1, 2, 3 and (no effect) stage 4
        cur = "R5";
        for (int s = 0; s <= 4; s++) begin
            step(1, 2'b00, 5'd7, 32'd3, 32'd5, (s == 0) ? 5'd7 : 5'd0, 0);
            for (int j = 1; j <= 4; j++)
                step(0, 2'b00, 5'd0, 0, 0, (j == s) ? 5'd7 : 5'd0, 0);
            idle(1);
        end

        // R6: zero and mismatching cancel values
        cur = "R6";
        step(1, 2'b01, 5'd12, 32'hDEAD_BEEF, 32'h1234_5678, 5'd0, 0);
        step(1, 2'b11, 5'd13, 32'hCAFE_0001, 32'h0000_FFFF, 5'd14, 0);
        step(0, 2'b00, 5'd0, 0, 0, 5'd15, 0);
        idle(5);

        // R7: destination zero never writes
        cur = "R7";
        step(1, 2'b00, 5'd0, 32'd9, 32'd9, 0, 0);
        idle(5);

        // R8: flush with all four stages full, and with an issue at the flush edge
        cur = "R8";
        for (int i = 0; i < 4; i++) step(1, 2'b10, 5'(20 + i), $urandom, $urandom, 0, 0);
        step(1, 2'b00, 5'd25, 32'd1, 32'd1, 0, 1);
        chk("R8", "busy after flush", {28'd0, stage_busy}, 32'd0);
        idle(5);

        // random mix
        cur = "R3";
        for (int i = 0; i < 400; i++) begin
            logic [4:0] rd;
            logic [4:0] cr;
            rd = 5'($urandom_range(0, 31));
            cr = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, 31)) : 5'd0;
            step($urandom_range(0, 3) != 0, 2'($urandom), rd, $urandom, $urandom, cr,
                 $urandom_range(0, 39) == 0);
        end
        idle(6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule